// File: doc/BRIEF.md
# Serial EEPROM Page Write Buffer

This block sits behind the bit engine of a two-wire serial EEPROM slave and turns a stream of received data bytes into a single page write of a 512-byte storage array. After the slave decodes an array address, the controller loads a 9-bit pointer. The top bit selects the bank, the next four bits select a 16-byte page, and the low four bits select a byte within that page. Each byte that the bit engine receives is reported with a flag that says whether its target block is write-protected. The controller answers every byte with an accept or reject result one cycle later.

Accepted bytes go into a 16-slot page buffer with a per-slot valid mask. Only the in-page offset advances, so a long burst wraps inside the page. When a Stop condition is detected and at least one byte is waiting, the controller issues a one-cycle write to the array port. That write carries the page index, the buffered bytes and the mask, and the array merges the masked bytes with the old page contents. A self-timed write interval then follows. Its length is a parameter in clock cycles, and during it every byte is refused and all commands are ignored.

Top module: `pwb_ctrl`

## Requirements
- R1: After reset, `busy`, `arr_we` and `resp_valid` are all 0.
- R2: When idle and not blocked, a received byte with `rx_prot`=0 produces `resp_valid`=1 and `resp_ack`=1 in the next cycle. The byte is stored in slot `ptr[3:0]` and that slot's mask bit (bit index = slot) is set.
- R3: Each accepted byte increments only pointer bits [3:0], modulo 16. Pointer bits [8:4] (bank in bit 8, page in bits 7:4) are unchanged, and `arr_page` equals pointer bits [8:4].
- R4: When more than 16 bytes are accepted before Stop, a later byte overwrites the earlier byte in the same slot. Only the last sixteen are committed.
- R5: A Stop while bytes are pending raises `arr_we` for exactly one cycle, in the cycle after the Stop strobe. `arr_mask` marks exactly the written slots, and `arr_data[8*i +: 8]` holds slot i. A write of fewer than 16 bytes still covers the whole page through the mask.
- R6: `busy` rises together with `arr_we` and stays high for exactly `WR_CYCLES` cycles.
- R7: While `busy` is high, every byte is answered with `resp_ack`=0 and is not stored. Pointer loads and Stop strobes have no effect, and no second `arr_we` occurs.
- R8: A byte with `rx_prot`=1 is answered with `resp_ack`=0 and discards the pending bytes. Later bytes are also refused until the next pointer load or Start. The Stop that follows causes no write and no busy interval.
- R9: A Start or Stop that arrives before any byte has been accepted starts no write. A Start also discards bytes already buffered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_start | input | 1 | Start condition detected (one-cycle strobe) |
| ptr_load | input | 1 | Array address received; load pointer |
| ptr_val | input | ADDR_W+1 | Pointer: bank bit on top, byte address below |
| rx_valid | input | 1 | Data byte received (one-cycle strobe) |
| rx_data | input | 8 | Received data byte |
| rx_prot | input | 1 | Target block of this byte is write-protected |
| bus_stop | input | 1 | Stop condition detected (one-cycle strobe) |
| busy | output | 1 | Self-timed write in progress |
| resp_valid | output | 1 | Accept/reject result valid for the previous byte |
| resp_ack | output | 1 | 1 = byte accepted, 0 = refused |
| arr_we | output | 1 | One-cycle page write strobe to the array |
| arr_page | output | ADDR_W+1-OFF_W | Bank and page index of the write |
| arr_mask | output | 2**OFF_W | Slots holding new data |
| arr_data | output | 8*2**OFF_W | Page buffer contents, slot i at bits 8i+7:8i |

## Verification
If the in-page offset were wrong, the first mismatch would appear in `arr_mask` or in the slot contents at the next commit. That commit comes one cycle after Stop. A stuck or miscounted write timer shows up as a busy interval of the wrong length, or as a refused byte after the interval should have ended. A lost blocked or fill state is exposed by the next `resp_ack` or by an `arr_we` where none is expected. The stimulus mixes random bursts of random length and start address with directed cases: a wrap past sixteen bytes, a protected byte in mid-stream, an aborted transfer, and traffic during the write interval.

// File: rtl/pwb_pkg.sv
package pwb_pkg;
  localparam int PWB_ADDR_W    = 8;
  localparam int PWB_OFF_W     = 4;
  localparam int PWB_WR_CYCLES = 500000;

  typedef enum logic [1:0] {
    PWB_IDLE  = 2'd0,
    PWB_FILL  = 2'd1,
    PWB_BLOCK = 2'd2,
    PWB_WRITE = 2'd3
  } pwb_state_e;
endpackage

// File: rtl/pwb_ptr.sv
module pwb_ptr #(
  parameter int ADDR_W = 8,
  parameter int OFF_W  = 4
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  load,
  input  logic [ADDR_W:0]       load_val,
  input  logic                  inc,
  output logic [ADDR_W-OFF_W:0] page,
  output logic [OFF_W-1:0]      off
);
  localparam logic [OFF_W-1:0] ONE = {{(OFF_W-1){1'b0}}, 1'b1};

  logic [ADDR_W:0] ptr_q, ptr_d;

  always_comb begin
    ptr_d = ptr_q;
    if (load)
      ptr_d = load_val;
    else if (inc)
      ptr_d = {ptr_q[ADDR_W:OFF_W], ptr_q[OFF_W-1:0] + ONE};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      ptr_q <= '0;
    else if (load || inc)
      ptr_q <= ptr_d;
  end

  assign page = ptr_q[ADDR_W:OFF_W];
  assign off  = ptr_q[OFF_W-1:0];
endmodule

// File: rtl/pwb_buf.sv
module pwb_buf #(
  parameter int OFF_W = 4
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      clr,
  input  logic                      wr,
  input  logic [OFF_W-1:0]          wr_off,
  input  logic [7:0]                wr_data,
  output logic [(1<<OFF_W)-1:0]     mask,
  output logic [(8<<OFF_W)-1:0]     data
);
  localparam int SLOTS = 1 << OFF_W;

  logic [SLOTS-1:0] mask_q, mask_d, sel;

  for (genvar i = 0; i < SLOTS; i++) begin : g_slot
    logic [7:0] slot_q;
    assign sel[i] = wr && (wr_off == OFF_W'(i));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        slot_q <= '0;
      else if (sel[i])
        slot_q <= wr_data;
    end
    assign data[8*i +: 8] = slot_q;
  end

  always_comb begin
    mask_d = mask_q;
    if (clr)
      mask_d = '0;
    else if (wr)
      mask_d = mask_q | sel;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      mask_q <= '0;
    else if (clr || wr)
      mask_q <= mask_d;
  end

  assign mask = mask_q;
endmodule

// File: rtl/pwb_timer.sv
module pwb_timer #(
  parameter int WR_CYCLES = 500000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load,
  input  logic run,
  output logic last
);
  localparam int CNT_W = $clog2(WR_CYCLES + 1);
  localparam logic [CNT_W-1:0] TOP = CNT_W'(WR_CYCLES - 1);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;

  assign cnt_en = load || (run && (cnt_q != '0));

  always_comb begin
    cnt_d = cnt_q;
    if (load)
      cnt_d = TOP;
    else if (run && (cnt_q != '0))
      cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      cnt_q <= '0;
    else if (cnt_en)
      cnt_q <= cnt_d;
  end

  assign last = (cnt_q == '0);
endmodule

// File: rtl/pwb_ctrl.sv
module pwb_ctrl
  import pwb_pkg::*;
#(
  parameter int ADDR_W    = PWB_ADDR_W,
  parameter int OFF_W     = PWB_OFF_W,
  parameter int WR_CYCLES = PWB_WR_CYCLES
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      bus_start,
  input  logic                      ptr_load,
  input  logic [ADDR_W:0]           ptr_val,
  input  logic                      rx_valid,
  input  logic [7:0]                rx_data,
  input  logic                      rx_prot,
  input  logic                      bus_stop,
  output logic                      busy,
  output logic                      resp_valid,
  output logic                      resp_ack,
  output logic                      arr_we,
  output logic [ADDR_W-OFF_W:0]     arr_page,
  output logic [(1<<OFF_W)-1:0]     arr_mask,
  output logic [(8<<OFF_W)-1:0]     arr_data
);
  localparam int SLOTS  = 1 << OFF_W;
  localparam int PAGE_W = ADDR_W + 1 - OFF_W;

  pwb_state_e state_q, state_d;

  logic              open_st, take, refuse_prot, commit, clr, t_last;
  logic [PAGE_W-1:0] cur_page;
  logic [OFF_W-1:0]  cur_off;
  logic [SLOTS-1:0]  buf_mask;

  assign open_st     = (state_q == PWB_IDLE) || (state_q == PWB_FILL);
  assign take        = rx_valid && !rx_prot && open_st;
  assign refuse_prot = rx_valid && rx_prot && (state_q != PWB_WRITE);
  assign commit      = bus_stop && (state_q == PWB_FILL);
  assign clr         = commit || ((state_q != PWB_WRITE) &&
                       (bus_start || ptr_load || refuse_prot));

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      PWB_IDLE:  if (refuse_prot) state_d = PWB_BLOCK;
                 else if (take)   state_d = PWB_FILL;
      PWB_FILL:  if (refuse_prot) state_d = PWB_BLOCK;
                 else if (commit) state_d = PWB_WRITE;
                 else if (bus_start || ptr_load) state_d = PWB_IDLE;
      PWB_BLOCK: if (bus_start || ptr_load || bus_stop) state_d = PWB_IDLE;
      PWB_WRITE: if (t_last) state_d = PWB_IDLE;
      default:   state_d = PWB_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      state_q <= PWB_IDLE;
    else
      state_q <= state_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      resp_valid <= 1'b0;
      resp_ack   <= 1'b0;
      arr_we     <= 1'b0;
    end else begin
      resp_valid <= rx_valid;
      resp_ack   <= take;
      arr_we     <= commit;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      arr_page <= '0;
      arr_mask <= '0;
    end else if (commit) begin
      arr_page <= cur_page;
      arr_mask <= buf_mask;
    end
  end

  pwb_ptr #(.ADDR_W(ADDR_W), .OFF_W(OFF_W)) u_ptr (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (ptr_load && (state_q != PWB_WRITE)),
    .load_val (ptr_val),
    .inc      (take),
    .page     (cur_page),
    .off      (cur_off)
  );

  pwb_buf #(.OFF_W(OFF_W)) u_buf (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr     (clr),
    .wr      (take),
    .wr_off  (cur_off),
    .wr_data (rx_data),
    .mask    (buf_mask),
    .data    (arr_data)
  );

  pwb_timer #(.WR_CYCLES(WR_CYCLES)) u_tmr (
    .clk   (clk),
    .rst_n (rst_n),
    .load  (commit),
    .run   (state_q == PWB_WRITE),
    .last  (t_last)
  );

  assign busy = (state_q == PWB_WRITE);
endmodule

// File: rtl/pwb_ctrl_chk.sv
module pwb_ctrl_chk #(
  parameter int OFF_W     = 4,
  parameter int WR_CYCLES = 500000
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  rx_valid,
  input logic                  rx_prot,
  input logic                  busy,
  input logic                  resp_valid,
  input logic                  resp_ack,
  input logic                  arr_we,
  input logic [(1<<OFF_W)-1:0] arr_mask
);
  int unsigned busy_run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      busy_run <= 0;
    else if (busy)
      busy_run <= busy_run + 1;
    else
      busy_run <= 0;
  end

  AST_RESP_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |=> resp_valid);                                   // R2
  AST_WE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    arr_we |=> !arr_we);                                        // R5
  AST_WE_HAS_MASK: assert property (@(posedge clk) disable iff (!rst_n)
    arr_we |-> (arr_mask != '0));                               // R5
  AST_WE_STARTS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    arr_we |-> (busy && busy_run == 0));                        // R6
  AST_BUSY_BOUNDED: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (busy_run < WR_CYCLES));                           // R6
  AST_BUSY_REFUSES: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && rx_valid) |=> !resp_ack);                          // R7
  AST_PROT_REFUSED: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && rx_prot) |=> !resp_ack);                       // R8
endmodule

bind pwb_ctrl pwb_ctrl_chk #(.OFF_W(OFF_W), .WR_CYCLES(WR_CYCLES)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .rx_valid   (rx_valid),
  .rx_prot    (rx_prot),
  .busy       (busy),
  .resp_valid (resp_valid),
  .resp_ack   (resp_ack),
  .arr_we     (arr_we),
  .arr_mask   (arr_mask)
);

// File: tb/pwb_ctrl_tb.sv
module pwb_ctrl_tb;
  localparam int WR = 20;

  logic         clk, rst_n;
  logic         bus_start, ptr_load, rx_valid, rx_prot, bus_stop;
  logic [8:0]   ptr_val;
  logic [7:0]   rx_data;
  logic         busy, resp_valid, resp_ack, arr_we;
  logic [4:0]   arr_page;
  logic [15:0]  arr_mask;
  logic [127:0] arr_data;

  int n_tests = 0;
  int n_fail  = 0;

  logic [4:0]  exp_page;
  logic [3:0]  exp_off;
  logic [15:0] exp_mask;
  logic [7:0]  exp_buf [16];
  bit          exp_blocked;

  pwb_ctrl #(.ADDR_W(8), .OFF_W(4), .WR_CYCLES(WR)) u_dut (
    .clk(clk), .rst_n(rst_n), .bus_start(bus_start), .ptr_load(ptr_load),
    .ptr_val(ptr_val), .rx_valid(rx_valid), .rx_data(rx_data),
    .rx_prot(rx_prot), .bus_stop(bus_stop), .busy(busy),
    .resp_valid(resp_valid), .resp_ack(resp_ack), .arr_we(arr_we),
    .arr_page(arr_page), .arr_mask(arr_mask), .arr_data(arr_data)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic chk(bit ok, string req, string what, int act, int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic int data_mismatches();
    int bad = 0;
    for (int i = 0; i < 16; i++)
      if (exp_mask[i] && arr_data[8*i +: 8] != exp_buf[i]) bad++;
    return bad;
  endfunction

  function automatic logic [3:0] next_off(logic [3:0] o);
    return o + 4'd1;
  endfunction

  task automatic do_start();
    bus_start = 1'b1; tick(); bus_start = 1'b0;
    exp_mask = '0; exp_blocked = 0;
  endtask

  task automatic do_addr(logic [8:0] a);
    ptr_load = 1'b1; ptr_val = a; tick(); ptr_load = 1'b0;
    exp_page = a[8:4]; exp_off = a[3:0]; exp_mask = '0; exp_blocked = 0;
  endtask

  task automatic send(logic [7:0] d, bit prot, string req);
    bit ea;
    rx_valid = 1'b1; rx_data = d; rx_prot = prot;
    tick();
    rx_valid = 1'b0; rx_prot = 1'b0;
    ea = !prot && !exp_blocked;
    chk(resp_valid == 1'b1 && resp_ack == ea, req, "byte response",
        int'({resp_valid, resp_ack}), int'({1'b1, ea}));
    if (ea) begin
      exp_buf[exp_off] = d;
      exp_mask[exp_off] = 1'b1;
      exp_off = next_off(exp_off);
    end
    if (prot) begin
      exp_blocked = 1; exp_mask = '0;
    end
  endtask

  task automatic stop_chk(string req);
    bit ec;
    int n;
    ec = (exp_mask != 0) && !exp_blocked;
    bus_stop = 1'b1; tick(); bus_stop = 1'b0;
    chk(arr_we == ec, req, "write strobe", int'(arr_we), int'(ec));
    if (ec) begin
      chk(arr_page == exp_page, req, "page index", int'(arr_page), int'(exp_page));
      chk(arr_mask == exp_mask, req, "slot mask", int'(arr_mask), int'(exp_mask));
      chk(data_mismatches() == 0, req, "slot data mismatches", data_mismatches(), 0);
      n = 0;
      while (busy && n < WR + 10) begin
        n++; tick();
      end
      chk(n == WR, "R6", "busy length", n, WR);
    end else begin
      chk(busy == 1'b0, req, "no busy after empty stop", int'(busy), 0);
    end
    exp_mask = '0; exp_blocked = 0;
  endtask

  initial begin
    #(200000 * 10);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    int n;
    void'($urandom(32'd4242));
    rst_n = 1'b0; bus_start = 0; ptr_load = 0; rx_valid = 0; rx_prot = 0;
    bus_stop = 0; ptr_val = '0; rx_data = '0;
    exp_mask = '0; exp_blocked = 0; exp_page = '0; exp_off = '0;
    for (int i = 0; i < 16; i++) exp_buf[i] = '0;
    tick(); tick();
    rst_n = 1'b1;
    tick();
    // R1 reset state
    chk(busy == 0 && arr_we == 0 && resp_valid == 0, "R1", "reset outputs",
        int'({busy, arr_we, resp_valid}), 0);

    // R2 R5: single byte in a partial page
    do_start(); do_addr(9'h123);
    send(8'hA5, 0, "R2");
    stop_chk("R5");

    // R3 R4: 20 bytes from offset 13, wrap inside page 0x0F of bank 0
    do_start(); do_addr(9'h0FD);
    for (int k = 0; k < 20; k++) send(8'(k + 8'h40), 0, "R3");
    chk(exp_mask == 16'hFFFF, "R4", "bench full mask", int'(exp_mask), 16'hFFFF);
    stop_chk("R4");

    // R8: protected byte mid-stream blocks the transfer
    do_start(); do_addr(9'h150);
    send(8'h11, 0, "R8"); send(8'h22, 0, "R8");
    send(8'h33, 1, "R8"); send(8'h44, 0, "R8");
    stop_chk("R8");

    // R9: stop without data, and start discarding buffered bytes
    do_start(); do_addr(9'h020);
    stop_chk("R9");
    do_start(); do_addr(9'h030);
    send(8'h77, 0, "R9"); send(8'h78, 0, "R9");
    do_start();
    stop_chk("R9");

    // R7: traffic during the write interval is ignored
    do_start(); do_addr(9'h1A3);
    send(8'h55, 0, "R7");
    bus_stop = 1'b1; tick(); bus_stop = 1'b0;
    chk(arr_we == 1, "R5", "write strobe before busy traffic", int'(arr_we), 1);
    exp_mask = '0;
    n = int'(busy);
    rx_valid = 1'b1; rx_data = 8'hAA; tick(); rx_valid = 1'b0; n += int'(busy);
    chk(resp_valid == 1 && resp_ack == 0, "R7", "byte during busy",
        int'({resp_valid, resp_ack}), 2);
    ptr_load = 1'b1; ptr_val = 9'h000; tick(); ptr_load = 1'b0; n += int'(busy);
    bus_stop = 1'b1; tick(); bus_stop = 1'b0; n += int'(busy);
    chk(arr_we == 0, "R7", "stop during busy", int'(arr_we), 0);
    while (busy && n < WR + 10) begin tick(); n += int'(busy); end
    chk(n == WR, "R6", "busy length with traffic", n, WR);
    // pointer kept: next byte lands at page 0x1A offset 4
    send(8'h66, 0, "R7");
    chk(exp_mask == 16'h0010, "R7", "bench slot after busy", int'(exp_mask), 16'h0010);
    stop_chk("R7");

    // Random bursts
    for (int t = 0; t < 8; t++) begin
      int len;
      do_start(); do_addr(9'($urandom()));
      len = 1 + int'($urandom() % 24);
      for (int k = 0; k < len; k++) send(8'($urandom()), 0, "R2");
      stop_chk("R5");
    end

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule